// File: doc/BRIEF.md
# Banked Register-File Data Memory with Pointer Indirection

This block is the data store of a small accumulator-style controller. The store is divided into banks of 128 bytes. An instruction names a 7-bit offset inside a bank, and two bank-select bits held in a small status register supply the bank. Two offsets are special, and they behave the same in every bank. Offset 0x00 is a doorway: touching it moves the access to the location named by an 8-bit pointer register, with a separate indirect-bank bit placed on top. Offset 0x04 is the pointer register itself, so software loads the pointer with an ordinary write.

A parameter selects 2 or 4 banks. With 2 banks, the upper bank bit is dropped, so addresses fold onto the banks that exist. Writes are committed on the rising clock edge. Reads are combinational from the resolved location. The status bits are loaded through a dedicated port and take effect from the next edge.

Top module: `bank_file_mem`

## Requirements
- R1: After reset, both bank-select bits, the indirect-bank bit and the pointer are 0. A read of offset 0x04 returns 0x00, and a read of offset 0x00 returns 0x00.
- R2: A direct access (offset not 0x00 or 0x04) reaches bank {bank_sel[1],bank_sel[0]} at the given offset, including offset 0x7F. A write lands on the rising edge, and a read shows the stored byte in the same cycle.
- R3: The same offset in different banks holds independent bytes.
- R4: An access to offset 0x00 goes to the location {bank_sel[2], ptr[7:0]}, meaning bank {bank_sel[2],ptr[7]} and offset ptr[6:0], for both reads and writes.
- R5: Offset 0x04 in every bank is the one pointer register. Writing it loads the pointer on the next edge, and reading it returns the pointer.
- R6: An indirect access whose pointer offset ptr[6:0] is 0x00 reads 0x00. A write through it changes nothing, and the pointer keeps its value.
- R7: With NUM_BANKS = 2, bank_sel[1] and bank_sel[2] are ignored, so bank 2 aliases bank 0 and bank 3 aliases bank 1.
- R8: While rd_en is low, rdata is 0x00.
- R9: bank_sel_we loads bank_sel_in into the status bits ({indirect bank, bank 1, bank 0} = bits 2,1,0) on the rising edge. An access in the same cycle still uses the old bits.
- R10: An indirect access whose pointer offset is 0x04 reaches the pointer register itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 7 | In-bank offset of the access |
| rd_en | input | 1 | Read enable |
| wr_en | input | 1 | Write enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| bank_sel_we | input | 1 | Load enable for the status bank bits |
| bank_sel_in | input | 3 | New status bits {indirect bank, bank 1, bank 0} |

## Verification
The hardest case to reach is an access that goes through the doorway offset and lands back on a special offset. The pointer must first be loaded through its mirror in some bank, and the status bits must be set so that the resolved bank differs from the direct bank. The stimulus table builds this up in order. It fills each bank at one offset, loads the pointer from a non-zero bank, and then reads and writes through offset 0x00 with the indirect-bank bit both clear and set. Last, it points the pointer at 0x00 and at 0x04 to reach the null location and the self-reference. A second instance with two banks receives the same stimulus, which exposes the folding of the upper bank bits.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  localparam int OFF_W      = 7;
  localparam int DATA_W     = 8;
  localparam int BANK_DEPTH = 1 << OFF_W;
  localparam int FULL_BANK_W = 2;

  localparam logic [OFF_W-1:0] OFF_DOOR = 7'h00;
  localparam logic [OFF_W-1:0] OFF_PTR  = 7'h04;

  typedef struct packed {
    logic       ind_bank;
    logic [1:0] dir_bank;
  } bank_sel_t;

  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_PTR  = 2'd1,
    TGT_NULL = 2'd2
  } tgt_e;
endpackage

// File: rtl/bfm_rst_sync.sv
module bfm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/bfm_ctrl_regs.sv
module bfm_ctrl_regs
  import bfm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  bank_sel_t         sel_in,
  input  logic              ptr_we,
  input  logic [DATA_W-1:0] ptr_in,
  output bank_sel_t         sel_q,
  output logic [DATA_W-1:0] ptr_q
);
  bank_sel_t         sel_d;
  logic [DATA_W-1:0] ptr_d;

  always_comb begin
    sel_d = sel_q;
    ptr_d = ptr_q;
    if (sel_we) sel_d = sel_in;
    if (ptr_we) ptr_d = ptr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ptr_q <= '0;
    end else begin
      sel_q <= sel_d;
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/bfm_addr_resolve.sv
module bfm_addr_resolve
  import bfm_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                   [OFF_W-1:0]  addr,
  input  bank_sel_t                           sel,
  input  logic                   [DATA_W-1:0] ptr,
  output logic                                is_ind,
  output logic                   [FULL_BANK_W-1:0] bank,
  output logic                   [OFF_W-1:0]  offset,
  output tgt_e                                tgt
);
  localparam logic [FULL_BANK_W-1:0] BANK_MASK = FULL_BANK_W'(NUM_BANKS - 1);

  logic [FULL_BANK_W-1:0] raw_bank;

  always_comb begin
    is_ind = (addr == OFF_DOOR);
    if (is_ind) begin
      raw_bank = {sel.ind_bank, ptr[DATA_W-1]};
      offset   = ptr[OFF_W-1:0];
    end else begin
      raw_bank = sel.dir_bank;
      offset   = addr;
    end
    bank = raw_bank & BANK_MASK;
    if (offset == OFF_PTR)                tgt = TGT_PTR;
    else if (is_ind && offset == OFF_DOOR) tgt = TGT_NULL;
    else                                  tgt = TGT_RAM;
  end
endmodule

// File: rtl/bfm_storage.sv
module bfm_storage
  import bfm_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [FULL_BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]       offset,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata
);
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic [DATA_W-1:0] cells [BANK_DEPTH];
    logic              bank_we;

    assign bank_we = we && (bank == FULL_BANK_W'(gb));

    always_ff @(posedge clk) begin
      if (bank_we) cells[offset] <= wdata;
    end

    assign bank_rd[gb] = cells[offset];
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank == FULL_BANK_W'(b)) rdata = bank_rd[b];
    end
  end
endmodule

// File: rtl/bank_file_mem.sv
module bank_file_mem
  import bfm_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              bank_sel_we,
  input  logic [2:0]        bank_sel_in
);
  logic                   rst_sync_n;
  bank_sel_t              sel_q;
  logic [DATA_W-1:0]      ptr_q;
  logic                   is_ind;
  logic [FULL_BANK_W-1:0] res_bank;
  logic [OFF_W-1:0]       res_off;
  tgt_e                   tgt;
  logic                   ram_we;
  logic                   ptr_we;
  logic [DATA_W-1:0]      ram_rdata;

  bfm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bfm_ctrl_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sel_we (bank_sel_we),
    .sel_in (bank_sel_t'(bank_sel_in)),
    .ptr_we (ptr_we),
    .ptr_in (wdata),
    .sel_q  (sel_q),
    .ptr_q  (ptr_q)
  );

  bfm_addr_resolve #(.NUM_BANKS(NUM_BANKS)) u_res (
    .addr   (addr),
    .sel    (sel_q),
    .ptr    (ptr_q),
    .is_ind (is_ind),
    .bank   (res_bank),
    .offset (res_off),
    .tgt    (tgt)
  );

  assign ram_we = wr_en && (tgt == TGT_RAM);
  assign ptr_we = wr_en && (tgt == TGT_PTR);

  bfm_storage #(.NUM_BANKS(NUM_BANKS)) u_mem (
    .clk    (clk),
    .we     (ram_we),
    .bank   (res_bank),
    .offset (res_off),
    .wdata  (wdata),
    .rdata  (ram_rdata)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (tgt)
        TGT_PTR:  rdata = ptr_q;
        TGT_NULL: rdata = '0;
        default:  rdata = ram_rdata;
      endcase
    end
  end
endmodule

// File: rtl/bank_file_mem_chk.sv
module bank_file_mem_chk
  import bfm_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              bank_sel_we,
  input logic [2:0]        bank_sel_in,
  input bank_sel_t         sel_q,
  input logic [DATA_W-1:0] ptr_q,
  input tgt_e              tgt,
  input logic              is_ind
);
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |-> rdata == '0); // R8
  AST_NULL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && tgt == TGT_NULL) |-> rdata == '0); // R6
  AST_NULL_ONLY_INDIRECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tgt == TGT_NULL) |-> is_ind); // R6
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && tgt == TGT_PTR) |=> ptr_q == $past(wdata)); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && tgt == TGT_PTR) |=> $stable(ptr_q)); // R5
  AST_PTR_READBACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && tgt == TGT_PTR) |-> rdata == ptr_q); // R10
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bank_sel_we |=> sel_q == $past(bank_sel_in)); // R9
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bank_sel_we |=> $stable(sel_q)); // R9
endmodule

bind bank_file_mem bank_file_mem_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .rd_en       (rd_en),
  .wr_en       (wr_en),
  .wdata       (wdata),
  .rdata       (rdata),
  .bank_sel_we (bank_sel_we),
  .bank_sel_in (bank_sel_in),
  .sel_q       (sel_q),
  .ptr_q       (ptr_q),
  .tgt         (tgt),
  .is_ind      (is_ind)
);

// File: tb/bank_file_mem_tb.sv
module bank_file_mem_tb;
  localparam int OP_SEL = 0;
  localparam int OP_WR  = 1;
  localparam int OP_RD  = 2;
  localparam int VEC_W  = 24;
  localparam int N_VEC  = 39;

  // fields: op[23:22] sel[21:19] addr[18:12] data[11:4] req[3:0]
  localparam logic [VEC_W-1:0] VECS [N_VEC] = '{
    {2'd2, 3'd0, 7'h04, 8'h00, 4'd1},  // R1 pointer reads 0 after reset
    {2'd2, 3'd0, 7'h00, 8'h00, 4'd1},  // R1 door via zero pointer
    {2'd1, 3'd0, 7'h10, 8'hA1, 4'd2},  // R2
    {2'd0, 3'd1, 7'h00, 8'h00, 4'd9},  // R9
    {2'd1, 3'd0, 7'h10, 8'hB2, 4'd3},  // R3
    {2'd0, 3'd2, 7'h00, 8'h00, 4'd9},
    {2'd1, 3'd0, 7'h10, 8'hC3, 4'd3},
    {2'd0, 3'd3, 7'h00, 8'h00, 4'd9},
    {2'd1, 3'd0, 7'h10, 8'hD4, 4'd3},
    {2'd2, 3'd0, 7'h10, 8'hD4, 4'd3},  // R3 bank 3
    {2'd0, 3'd2, 7'h00, 8'h00, 4'd9},
    {2'd2, 3'd0, 7'h10, 8'hC3, 4'd3},  // R3 bank 2
    {2'd0, 3'd0, 7'h00, 8'h00, 4'd9},
    {2'd2, 3'd0, 7'h10, 8'hA1, 4'd2},  // R2 bank 0
    {2'd1, 3'd0, 7'h7F, 8'h5A, 4'd2},
    {2'd2, 3'd0, 7'h7F, 8'h5A, 4'd2},  // R2 top offset
    {2'd0, 3'd1, 7'h00, 8'h00, 4'd9},
    {2'd1, 3'd0, 7'h04, 8'h90, 4'd5},  // R5 load pointer from bank 1
    {2'd0, 3'd2, 7'h00, 8'h00, 4'd9},
    {2'd2, 3'd0, 7'h04, 8'h90, 4'd5},  // R5 mirror in bank 2
    {2'd2, 3'd0, 7'h00, 8'hB2, 4'd4},  // R4 -> bank 1 off 0x10
    {2'd0, 3'd6, 7'h00, 8'h00, 4'd9},
    {2'd2, 3'd0, 7'h00, 8'hD4, 4'd4},  // R4 ind bank set -> bank 3
    {2'd1, 3'd0, 7'h00, 8'h55, 4'd4},  // R4 write through door
    {2'd0, 3'd3, 7'h00, 8'h00, 4'd9},
    {2'd2, 3'd0, 7'h10, 8'h55, 4'd4},  // R4 landed in bank 3
    {2'd0, 3'd0, 7'h00, 8'h00, 4'd9},
    {2'd1, 3'd0, 7'h04, 8'h80, 4'd6},
    {2'd1, 3'd0, 7'h00, 8'h77, 4'd6},  // R6 write to null
    {2'd2, 3'd0, 7'h00, 8'h00, 4'd6},  // R6 null reads 0
    {2'd2, 3'd0, 7'h04, 8'h80, 4'd6},  // R6 pointer untouched
    {2'd0, 3'd1, 7'h00, 8'h00, 4'd9},
    {2'd2, 3'd0, 7'h10, 8'hB2, 4'd6},  // R6 bank 1 untouched
    {2'd1, 3'd0, 7'h04, 8'h04, 4'd10},
    {2'd2, 3'd0, 7'h00, 8'h04, 4'd10}, // R10 door reads pointer
    {2'd1, 3'd0, 7'h00, 8'h22, 4'd10}, // R10 door writes pointer
    {2'd2, 3'd0, 7'h04, 8'h22, 4'd10}, // R10
    {2'd1, 3'd0, 7'h04, 8'h10, 4'd4},
    {2'd2, 3'd0, 7'h00, 8'hA1, 4'd4}   // R4 bank 1 sel, pointer to bank 0
  };

  logic       clk;
  logic       rst_n;
  logic [6:0] addr;
  logic       rd_en;
  logic       wr_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [7:0] rdata2;
  logic       bank_sel_we;
  logic [2:0] bank_sel_in;
  int         n_checks;
  int         n_fail;
  bit         done;

  bank_file_mem #(.NUM_BANKS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .bank_sel_we(bank_sel_we), .bank_sel_in(bank_sel_in)
  );

  bank_file_mem #(.NUM_BANKS(2)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata2), .bank_sel_we(bank_sel_we), .bank_sel_in(bank_sel_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    addr = '0; rd_en = 0; wr_en = 0; wdata = '0; bank_sel_we = 0; bank_sel_in = '0;
  endtask

  // one cycle: drive at negedge, check read mid-low phase, commit at posedge
  task automatic step(int op, logic [2:0] sel, logic [6:0] a, logic [7:0] d,
                      string req, bit use2);
    @(negedge clk);
    idle();
    addr = a;
    if (op == OP_SEL) begin bank_sel_we = 1; bank_sel_in = sel; end
    if (op == OP_WR)  begin wr_en = 1; wdata = d; end
    if (op == OP_RD)  rd_en = 1;
    #2;
    if (op == OP_RD) check(req, use2 ? rdata2 : rdata, d);
    @(posedge clk);
    #1 idle();
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      logic [VEC_W-1:0] v;
      v = VECS[i];
      step(int'(v[23:22]), v[21:19], v[18:12], v[11:4],
           $sformatf("R%0d vec %0d", v[3:0], i), 1'b0);
    end

    // R8: no read enable -> zero output although 0x10 holds data
    @(negedge clk);
    idle(); addr = 7'h10; #2;
    check("R8", rdata, 8'h00);

    // R9: bits load at the edge, same-cycle access uses old bank (bank 1)
    @(negedge clk);
    idle(); addr = 7'h10; rd_en = 1; bank_sel_we = 1; bank_sel_in = 3'd3; #2;
    check("R9 before edge", rdata, 8'hB2);
    @(posedge clk);
    #1 bank_sel_we = 0;
    @(negedge clk); #2;
    check("R9 after edge", rdata, 8'h55);
    @(posedge clk); #1 idle();

    // R7: two-bank instance folds upper bank bits
    step(OP_SEL, 3'd0, 7'h00, 8'h00, "R7", 1'b1);
    step(OP_WR,  3'd0, 7'h20, 8'h11, "R7", 1'b1);
    step(OP_SEL, 3'd2, 7'h00, 8'h00, "R7", 1'b1);
    step(OP_RD,  3'd0, 7'h20, 8'h11, "R7 bank2 aliases bank0", 1'b1);
    step(OP_SEL, 3'd3, 7'h00, 8'h00, "R7", 1'b1);
    step(OP_WR,  3'd0, 7'h20, 8'h22, "R7", 1'b1);
    step(OP_SEL, 3'd1, 7'h00, 8'h00, "R7", 1'b1);
    step(OP_RD,  3'd0, 7'h20, 8'h22, "R7 bank3 aliases bank1", 1'b1);
    step(OP_WR,  3'd0, 7'h04, 8'hA0, "R7", 1'b1);
    step(OP_SEL, 3'd4, 7'h00, 8'h00, "R7", 1'b1);
    step(OP_RD,  3'd0, 7'h00, 8'h22, "R7 indirect bank bit ignored", 1'b1);

    // R1: reset in mid-run clears pointer and bank bits
    @(negedge clk) rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    step(OP_RD, 3'd0, 7'h04, 8'h00, "R1 pointer after reset", 1'b0);
    step(OP_RD, 3'd0, 7'h00, 8'h00, "R1 door after reset", 1'b0);
    step(OP_RD, 3'd0, 7'h04, 8'h00, "R1 two-bank pointer", 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule